// File: doc/BRIEF.md
# Nibble-Serial Debug Memory Monitor

This block lets an external debug probe read and write on-chip memory while the system runs. The probe sends 4-bit nibbles, and a strobe input qualifies each one. The block checks the framing and builds an address, plus a write value when the command is a write. It then performs exactly one access on an internal request/acknowledge memory bus.

A frame always opens with a zero nibble. A command nibble follows, carrying the direction and the access width. Then come eight address nibbles, least significant first. A write adds 2, 4 or 8 data nibbles, also least significant first. A read has no data field. After its access completes, the fetched value goes back to the probe on a separate nibble output with its own valid strobe.

If the framing is wrong, the block drops the frame, pulses an error flag and waits for a new frame. While a bus access is outstanding, the block shows busy and ignores all strobed input.

Top module: `nmon_top`

## Requirements
- R1: A nibble is taken only on a rising clock edge where `nib_strobe` is 1. Values on `nib_in` while the strobe is 0 have no effect on the frame.
- R2: The first nibble of a frame must be 4'b0000. Any other value raises `frame_err` for one cycle, starting the cycle after that edge, and the block keeps waiting for a first nibble.
- R3: The second nibble is the command. Bit 3 must be 1, bit 2 selects write (1) or read (0), and bits 1:0 select the width (00 = 8-bit, 01 = 16-bit, 10 = 32-bit). If bit 3 is 0 or the width code is 11, `frame_err` pulses for one cycle and the block waits for a new frame.
- R4: The next eight nibbles form `bus_addr`, least significant nibble first.
- R5: On a write, 2, 4 or 8 data nibbles follow, by width and least significant first. They appear on `bus_wdata` with all bits above the access width at 0, and `bus_we` is 1.
- R6: On a read, the access starts right after the eighth address nibble, with no data field, and `bus_we` is 0.
- R7: `bus_req` rises in the cycle after the edge that takes the last nibble of a frame. Address, write data, direction and width stay stable until the edge where `bus_ack` is 1, and `bus_req` is 0 from the next cycle. Each frame gives exactly one access, and an incomplete frame gives none.
- R8: `busy` is 1 exactly while `bus_req` is outstanding. Strobed nibbles in that time are ignored, so the next frame is parsed from its own first nibble.
- R9: After the acknowledge edge of a read, `rd_valid` is 1 for 2, 4 or 8 consecutive cycles, by width. During those cycles `rd_nib` carries the `bus_rdata` value sampled at that edge, least significant nibble first.
- R10: A synchronous active-high `rst` drives all outputs to 0 and discards any partly received frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nib_strobe | input | 1 | Qualifies `nib_in` on this edge |
| nib_in | input | 4 | Nibble from the probe |
| busy | output | 1 | A bus access is outstanding |
| frame_err | output | 1 | One-cycle framing error pulse |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_size | output | 2 | Access width code |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write value, upper bits zero |
| bus_rdata | input | 32 | Read value from memory |
| bus_ack | input | 1 | Access complete |
| rd_valid | output | 1 | `rd_nib` holds a returned nibble |
| rd_nib | output | 4 | Returned read nibble |

## Verification
The hardest case to reach from the ports is input arriving while an access is held open. In that state, strobed nibbles that would form a valid opening must still be dropped. To get there, the stimulus holds back `bus_ack` for several cycles after a complete read frame and sends a zero nibble followed by a legal command nibble during the wait. It then sends a fresh frame and checks that its address and direction decode correctly. A second hard case is a partial frame cut off by reset, which is checked by sending a full frame right after the reset.

// File: rtl/nmon_pkg.sv
package nmon_pkg;

  typedef enum logic [2:0] {
    RX_SPARE = 3'd0,
    RX_CMD   = 3'd1,
    RX_ADDR  = 3'd2,
    RX_DATA  = 3'd3,
    RX_WAIT  = 3'd4
  } rx_state_e;

  // Number of data nibbles carried by a width code.
  function automatic logic [3:0] data_nibs(input logic [1:0] sz);
    case (sz)
      2'b00:   return 4'd2;
      2'b01:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  // A command nibble is legal when its marker bit is set and the width code is defined.
  function automatic logic cmd_ok(input logic [3:0] c);
    return c[3] && (c[1:0] != 2'b11);
  endfunction

endpackage

// File: rtl/nmon_rx.sv
module nmon_rx
  import nmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [3:0]        nib,
  input  logic              bus_done,
  output logic              busy,
  output logic              nib_take,
  output logic              frame_go,
  output logic              frame_err,
  output logic              we,
  output logic [1:0]        size,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int DATA_NIBS = DATA_W / 4;
  localparam int MAX_NIBS  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
  localparam int CNT_W     = $clog2(MAX_NIBS) + 1;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic              we_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic              err_q;

  logic last_addr, last_data, bad_nib, cmd_take, data_take;

  assign nib_take  = strobe && (state != RX_WAIT);
  assign last_addr = (state == RX_ADDR) && (cnt == CNT_W'(ADDR_NIBS - 1));
  assign last_data = (state == RX_DATA) && (cnt == CNT_W'(data_nibs(size_q) - 4'd1));
  assign frame_go  = nib_take && ((last_addr && !we_q) || last_data);
  assign cmd_take  = nib_take && (state == RX_CMD) && cmd_ok(nib);
  assign data_take = nib_take && (state == RX_DATA);
  assign bad_nib   = nib_take &&
                     (((state == RX_SPARE) && (nib != 4'h0)) ||
                      ((state == RX_CMD) && !cmd_ok(nib)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_SPARE;
      cnt    <= '0;
      we_q   <= 1'b0;
      size_q <= 2'b00;
      addr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= bad_nib;
      case (state)
        RX_SPARE: if (nib_take && nib == 4'h0) state <= RX_CMD;
        RX_CMD: if (nib_take) begin
          if (cmd_ok(nib)) begin
            we_q   <= nib[2];
            size_q <= nib[1:0];
            cnt    <= '0;
            state  <= RX_ADDR;
          end else begin
            state <= RX_SPARE;
          end
        end
        RX_ADDR: if (nib_take) begin
          addr_q <= {nib, addr_q[ADDR_W-1:4]};
          if (last_addr) begin
            cnt   <= '0;
            state <= we_q ? RX_DATA : RX_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: if (nib_take) begin
          if (last_data) state <= RX_WAIT;
          else cnt <= cnt + 1'b1;
        end
        RX_WAIT: if (bus_done) state <= RX_SPARE;
        default: state <= RX_SPARE;
      endcase
    end
  end

  // One register slice per data nibble; cleared when a new command is taken.
  for (genvar g = 0; g < DATA_NIBS; g++) begin : g_wd
    always_ff @(posedge clk) begin
      if (rst || cmd_take) begin
        wdata[g*4 +: 4] <= 4'h0;
      end else if (data_take && cnt == CNT_W'(g)) begin
        wdata[g*4 +: 4] <= nib;
      end
    end
  end

  assign busy      = (state == RX_WAIT);
  assign frame_err = err_q;
  assign we        = we_q;
  assign size      = size_q;
  assign addr      = addr_q;
endmodule

// File: rtl/nmon_bus.sv
module nmon_bus (
  input  logic clk,
  input  logic rst,
  input  logic frame_go,
  input  logic ack,
  output logic req,
  output logic done
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else if (frame_go) req <= 1'b1;
    else if (req && ack) req <= 1'b0;
  end

  assign done = req && ack;
endmodule

// File: rtl/nmon_tx.sv
module nmon_tx
  import nmon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] rdata,
  output logic              valid,
  output logic [3:0]        nib
);
  logic [DATA_W-1:0] shreg;
  logic [3:0]        left;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      left  <= 4'd0;
    end else if (load) begin
      shreg <= rdata;
      left  <= data_nibs(size);
    end else if (left != 4'd0) begin
      shreg <= {4'h0, shreg[DATA_W-1:4]};
      left  <= left - 4'd1;
    end
  end

  assign valid = (left != 4'd0);
  assign nib   = valid ? shreg[3:0] : 4'h0;
endmodule

// File: rtl/nmon_top.sv
module nmon_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nib_strobe,
  input  logic [3:0]        nib_in,
  output logic              busy,
  output logic              frame_err,
  output logic              bus_req,
  output logic              bus_we,
  output logic [1:0]        bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              rd_valid,
  output logic [3:0]        rd_nib
);
  logic nib_take, frame_go, bus_done, rd_load;

  nmon_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .strobe(nib_strobe), .nib(nib_in),
    .bus_done(bus_done), .busy(busy), .nib_take(nib_take),
    .frame_go(frame_go), .frame_err(frame_err), .we(bus_we),
    .size(bus_size), .addr(bus_addr), .wdata(bus_wdata)
  );

  nmon_bus u_bus (
    .clk(clk), .rst(rst), .frame_go(frame_go), .ack(bus_ack),
    .req(bus_req), .done(bus_done)
  );

  assign rd_load = bus_done && !bus_we;

  nmon_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .load(rd_load), .size(bus_size),
    .rdata(bus_rdata), .valid(rd_valid), .nib(rd_nib)
  );
endmodule

// File: rtl/nmon_chk.sv
module nmon_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              frame_err,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic              nib_take,
  input logic              frame_go,
  input logic              bus_done
);
  AST_RST_QUIET: assert property (@(posedge clk) rst |=> (!bus_req && !busy && !rd_valid && !frame_err)); // R10
  AST_BUSY_IS_REQ: assert property (@(posedge clk) disable iff (rst) busy == bus_req); // R8
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst) busy |-> !nib_take); // R8
  AST_GO_RAISES_REQ: assert property (@(posedge clk) disable iff (rst) frame_go |=> bus_req); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we) && $stable(bus_size))); // R7
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst) bus_done |=> !bus_req); // R7
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst) bus_req |-> (bus_size != 2'b11)); // R3
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (rst) frame_err |-> !bus_req); // R2
  AST_RET_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> ($past(bus_done) && !$past(bus_we))); // R9
endmodule

bind nmon_top nmon_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .frame_err(frame_err),
  .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we), .bus_size(bus_size),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
  .nib_take(nib_take), .frame_go(frame_go), .bus_done(bus_done)
);

// File: tb/tb_nmon_top.sv
module tb_nmon_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nib_strobe = 1'b0;
  logic [3:0]  nib_in = 4'h0;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;
  logic        busy, frame_err, bus_req, bus_we, rd_valid;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  rd_nib;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmon_top dut (
    .clk(clk), .rst(rst), .nib_strobe(nib_strobe), .nib_in(nib_in),
    .busy(busy), .frame_err(frame_err), .bus_req(bus_req), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .rd_valid(rd_valid), .rd_nib(rd_nib)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nib_count(input logic [1:0] sz);
    return 2 << sz;
  endfunction

  function automatic logic [31:0] width_mask(input logic [1:0] sz);
    return 32'hFFFF_FFFF >> (32 - (8 << sz));
  endfunction

  task automatic send_nib(input logic [3:0] n);
    nib_in = n;
    nib_strobe = 1'b1;
    @(negedge clk);
    nib_strobe = 1'b0;
    nib_in = 4'h0;
  endtask

  // Garbage on the nibble lines with the strobe low (R1).
  task automatic idle_noise(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      nib_in = 4'(i * 5 + 3);
      @(negedge clk);
    end
    nib_in = 4'h0;
  endtask

  task automatic send_frame(input logic we, input logic [1:0] sz, input logic [31:0] a,
                            input logic [31:0] d, input int gap);
    send_nib(4'h0);
    send_nib({1'b1, we, sz});
    for (int i = 0; i < 8; i++) begin
      if (gap > 0) idle_noise(gap);
      send_nib(a[i*4 +: 4]);
      if (i < 7 || we) chk(bus_req == 1'b0, "R7 no early req", 64'(bus_req), 0);
    end
    if (we) begin
      for (int i = 0; i < nib_count(sz); i++) begin
        if (gap > 0) idle_noise(gap);
        send_nib(d[i*4 +: 4]);
      end
    end
  endtask

  // Called at the negedge right after the final nibble edge.
  task automatic serve(input logic we, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] d, input logic [31:0] rdat, input int lat);
    chk(bus_req == 1'b1, "R7 req after frame", 64'(bus_req), 1);
    chk(busy == 1'b1, "R8 busy during access", 64'(busy), 1);
    chk(bus_addr == a, "R4 address", 64'(bus_addr), 64'(a));
    chk(bus_we == we, we ? "R5 write dir" : "R6 read dir", 64'(bus_we), 64'(we));
    chk(bus_size == sz, "R3 size", 64'(bus_size), 64'(sz));
    if (we) chk(bus_wdata == (d & width_mask(sz)), "R5 wdata", 64'(bus_wdata), 64'(d & width_mask(sz)));
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(bus_req == 1'b1 && bus_addr == a, "R7 held", 64'(bus_addr), 64'(a));
    end
    bus_rdata = rdat;
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
    bus_rdata = 32'hDEAD_BEEF;
    chk(bus_req == 1'b0, "R7 req drops", 64'(bus_req), 0);
    chk(busy == 1'b0, "R8 busy drops", 64'(busy), 0);
    if (!we) begin
      for (int i = 0; i < nib_count(sz); i++) begin
        chk(rd_valid == 1'b1 && rd_nib == rdat[i*4 +: 4], "R9 return nibble",
            {59'(rd_valid), 1'b0, rd_nib}, {59'd1, 1'b0, rdat[i*4 +: 4]});
        @(negedge clk);
      end
    end
    chk(rd_valid == 1'b0, "R9 return length", 64'(rd_valid), 0);
    chk(bus_req == 1'b0, "R7 single access", 64'(bus_req), 0);
  endtask

  task automatic t_reset();
    chk(!busy && !bus_req && !rd_valid && !frame_err, "R10 reset outputs",
        {busy, bus_req, rd_valid, frame_err}, 0);
  endtask

  task automatic t_write(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d, input int gap);
    send_frame(1'b1, sz, a, d, gap);
    serve(1'b1, sz, a, d, 32'h0, 2);
  endtask

  task automatic t_read(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] r, input int lat);
    send_frame(1'b0, sz, a, 32'h0, 0);
    serve(1'b0, sz, a, 32'h0, r, lat);
  endtask

  task automatic t_bad_spare();
    send_nib(4'h5);
    chk(frame_err == 1'b1, "R2 spare error", 64'(frame_err), 1);
    @(negedge clk);
    chk(frame_err == 1'b0, "R2 error one cycle", 64'(frame_err), 0);
    t_read(2'b01, 32'h0000_1234, 32'h0000_ABCD, 1);
  endtask

  task automatic t_bad_cmd(input logic [3:0] c);
    send_nib(4'h0);
    send_nib(c);
    chk(frame_err == 1'b1, "R3 command error", 64'(frame_err), 1);
    @(negedge clk);
    chk(frame_err == 1'b0 && bus_req == 1'b0, "R3 frame dropped", {frame_err, bus_req}, 0);
    t_write(2'b00, 32'h8000_0001, 32'h0000_00C3, 0);
  endtask

  task automatic t_busy_ignore();
    send_frame(1'b0, 2'b10, 32'h1357_9BDF, 32'h0, 0);
    send_nib(4'h0);
    send_nib(4'hC);
    send_nib(4'h7);
    serve(1'b0, 2'b10, 32'h1357_9BDF, 32'h0, 32'h0F1E_2D3C, 0);
    t_write(2'b01, 32'h2468_ACE0, 32'h0000_55AA, 0);
  endtask

  task automatic t_reset_mid();
    send_nib(4'h0);
    send_nib(4'hE);
    send_nib(4'h1);
    send_nib(4'h2);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_read(2'b00, 32'hCAFE_0042, 32'h0000_0096, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write(2'b10, 32'h89AB_CDEF, 32'h1234_5678, 0);
    t_write(2'b00, 32'h0000_0010, 32'hFFFF_FF5A, 0);
    t_write(2'b01, 32'hFFFF_FFFE, 32'h7777_BEEF, 2);
    t_read(2'b10, 32'h0123_4567, 32'hA5C3_9E17, 3);
    t_read(2'b00, 32'h4000_0003, 32'hFFFF_FF81, 0);
    t_bad_spare();
    t_bad_cmd(4'h4);
    t_bad_cmd(4'hB);
    t_busy_ignore();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule